// File: doc/BRIEF.md
# Power-off wake reset sequencer

This block sequences the clocking domain of a small microcontroller out of and into a power-off state. It runs on the always-on 32.768 kHz timekeeping clock. It watches an external cold-reset input, an active-low I/O reset input and a ready flag from each of four PLLs. From these it drives the four PLL enables, a high-true system reset and a power-off flag.

While the I/O reset input is low the block stays powered off: every PLL is disabled and the system reset is held. When the I/O reset input rises, the block starts the wake sequence. It brings the PLLs up in dependency order and runs a start-up timer. The length of the timer comes from a start-up time register that software programs in units of 32 ms. The system reset is released only when the timer has expired, all four PLLs report ready and neither reset input is active.

A one-cycle mode-change pulse lets software or an indicator pin see each transition between the power-off, waking and running modes. A sticky timeout flag records a start-up window that closed before every PLL was ready.

Top module: `pwr_wake_seq`

## Requirements
- R1: Once the I/O reset input has been low for three consecutive clock edges, `pwr_off_o` is 1, all of `pll_en_o` are 0 and `rst_drv_o` is 1. These values hold for as long as the input stays low.
- R2: PLL bit order is 0 = intermediate, 1 = low-speed, 2 = high-speed, 3 = video. Outside power-off, bit 0 is enabled. Bit 1 is enabled only while PLL 0 is ready. Bits 2 and 3 are enabled only while PLLs 0 and 1 are both ready.
- R3: If a PLL ready flag drops while running, its downstream enables drop in the same cycle. `rst_drv_o` is reasserted on the next clock edge, and a full start-up window is then needed before it is released again.
- R4: `rst_drv_o` falls only after all of the following hold: the start-up timer has counted (programmed units × TICKS_PER_UNIT) clocks in the waking mode, all four ready flags are 1, and neither reset input is active. The count starts after the two-flop synchronizer.
- R5: A write with `cfg_addr_i` = 8'h8F loads the 5-bit start-up register, which is read on `cfg_rdata_o`. A value below 8 is stored as 8. A write to any other address leaves the register unchanged.
- R6: An active external reset forces the start-up register to 8 (256 ms) and clears the timeout flag. Passing through power-off keeps the programmed value.
- R7: If the I/O reset input falls during the wake sequence, the block returns to power-off and clears the timer. The next wake takes a full start-up window.
- R8: If the start-up timer expires while any PLL is not ready, `timeout_o` is set. It stays set until an external reset, and `rst_drv_o` stays high until all PLLs are ready.
- R9: `mode_evt_o` pulses high for exactly one cycle each time the mode changes between power-off, waking and running. It pulses in the same cycle that `pwr_off_o` or `rst_drv_o` changes.
- R10: After `rst_n` is applied, the outputs are: `pwr_off_o` = 1, `rst_drv_o` = 1, `pll_en_o` = 0, `timeout_o` = 0, `mode_evt_o` = 0 and `cfg_rdata_o` = 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on 32.768 kHz clock |
| rst_n | input | 1 | Synchronous active-low reset of the always-on logic |
| ext_rst_i | input | 1 | External cold reset, active high, asynchronous |
| io_rst_n_i | input | 1 | I/O reset, low requests power-off, asynchronous |
| pll_rdy_i | input | 4 | Per-PLL ready flags, synchronous to clk |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Configuration index |
| cfg_wdata_i | input | 5 | Start-up time in 32 ms units |
| cfg_rdata_o | output | 5 | Current start-up register value |
| pll_en_o | output | 4 | Per-PLL enables |
| rst_drv_o | output | 1 | System reset drive, high true |
| pwr_off_o | output | 1 | Block is in power-off |
| timeout_o | output | 1 | Sticky start-up timeout |
| mode_evt_o | output | 1 | One-cycle pulse on a mode change |

## Verification
The assertions check on every cycle that power-off keeps all PLLs down and reset held, and that the enable chain never gets ahead of the ready flags. They also check that reset is released only with all PLLs ready and the I/O reset inactive, and that a loss of ready reasserts reset. Each mode change must come with the event pulse, and the timeout flag may clear only on a cold reset. The length of the start-up window, the effect of the programmed value and its clamping, the timer clearing on an abort, the value kept across power-off and the restore to 256 ms on a cold reset can only be shown by the bench's timed scenarios.

// File: rtl/pwr_wake_pkg.sv
// Package: shared types and fixed PLL positions for the wake sequencer.
// Assumes four PLLs whose dependency chain is fixed by the positions below.
package pwr_wake_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WAKE = 2'd1,
        ST_RUN  = 2'd2
    } pws_state_e;

    localparam int PLL_MID  = 0;
    localparam int PLL_LOW  = 1;
    localparam int PLL_HIGH = 2;
    localparam int PLL_VID  = 3;
    localparam int N_PLL    = 4;
endpackage

// File: rtl/pws_sync2.sv
// Two-flop synchronizer for a vector of independent asynchronous inputs.
// Assumes each bit is sampled on its own; no multi-bit coherency is needed.
module pws_sync2 #(
    parameter int          WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    // Purpose: shift each input through two flops into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/pws_timer.sv
// Start-up timer: a prescaler divides clk into time units and a unit counter
// counts up to a limit. It assumes the limit stays constant while it runs.
// Clear has priority, and the count freezes once it expires.
module pws_timer #(
    parameter int TICKS_PER_UNIT = 1048,
    parameter int UNIT_W         = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              run_i,
    input  logic [UNIT_W-1:0] limit_i,
    output logic              expired_o
);
    localparam int PRE_W = (TICKS_PER_UNIT > 1) ? $clog2(TICKS_PER_UNIT) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_UNIT - 1);

    logic [PRE_W-1:0]  pre_q;
    logic [UNIT_W-1:0] units_q;

    assign expired_o = (units_q >= limit_i);

    // Purpose: advance the prescaler and unit count while running.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            pre_q   <= '0;
            units_q <= '0;
        end else if (run_i && !expired_o) begin
            if (pre_q == PRE_LAST) begin
                pre_q   <= '0;
                units_q <= units_q + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pws_pll_chain.sv
// PLL enable chain: the intermediate PLL comes first, and the low-speed PLL
// needs it ready. The high-speed and video PLLs need both earlier PLLs ready.
// Assumes the ready flags are already synchronous to clk.
module pws_pll_chain
    import pwr_wake_pkg::*;
(
    input  logic             active_i,
    input  logic [N_PLL-1:0] rdy_i,
    output logic [N_PLL-1:0] en_o
);
    logic mid_up;
    logic base_up;

    assign mid_up  = active_i && rdy_i[PLL_MID];
    assign base_up = mid_up && rdy_i[PLL_LOW];

    assign en_o[PLL_MID] = active_i;
    assign en_o[PLL_LOW] = mid_up;

    genvar g;
    generate
        for (g = PLL_HIGH; g < N_PLL; g++) begin : g_fast
            assign en_o[g] = base_up;
        end
    endgenerate
endmodule

// File: rtl/pwr_wake_seq.sv
// Top of the wake sequencer. A mode machine moves between power-off, waking
// and running. It drives the PLL enable chain, runs the start-up timer,
// holds the start-up register and reports a sticky timeout flag.
// Assumes clk is the always-on clock and that both reset inputs are
// asynchronous, while the PLL ready flags are synchronous.
module pwr_wake_seq
    import pwr_wake_pkg::*;
#(
    parameter int          TICKS_PER_UNIT = 1048,
    parameter int          UNIT_W         = 5,
    parameter int          MIN_UNITS      = 8,
    parameter int          ADDR_W         = 8,
    parameter logic [7:0]  CFG_INDEX      = 8'h8F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_rst_i,
    input  logic              io_rst_n_i,
    input  logic [3:0]        pll_rdy_i,
    input  logic              cfg_we_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic [UNIT_W-1:0] cfg_wdata_i,
    output logic [UNIT_W-1:0] cfg_rdata_o,
    output logic [3:0]        pll_en_o,
    output logic              rst_drv_o,
    output logic              pwr_off_o,
    output logic              timeout_o,
    output logic              mode_evt_o
);
    localparam logic [UNIT_W-1:0] FLOOR = UNIT_W'(MIN_UNITS);
    localparam logic [ADDR_W-1:0] INDEX = ADDR_W'(CFG_INDEX);

    logic [1:0]        sync_s;
    logic              ext_s;
    logic              io_s;
    pws_state_e        state_q;
    pws_state_e        state_d;
    logic [UNIT_W-1:0] start_q;
    logic              expired;
    logic              all_rdy;
    logic              timeout_q;
    logic              evt_q;

    pws_sync2 #(.WIDTH(2), .RST_VAL(2'b00)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({ext_rst_i, io_rst_n_i}),
        .q_o   (sync_s)
    );
    assign ext_s   = sync_s[1];
    assign io_s    = sync_s[0];
    assign all_rdy = &pll_rdy_i;

    pws_timer #(.TICKS_PER_UNIT(TICKS_PER_UNIT), .UNIT_W(UNIT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   ((state_q != ST_WAKE) || ext_s),
        .run_i     (state_q == ST_WAKE),
        .limit_i   (start_q),
        .expired_o (expired)
    );

    pws_pll_chain u_chain (
        .active_i (state_q != ST_OFF),
        .rdy_i    (pll_rdy_i),
        .en_o     (pll_en_o)
    );

    // Purpose: choose the next mode; a low I/O reset always wins.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  if (io_s) state_d = ST_WAKE;
            ST_WAKE: if (expired && all_rdy && !ext_s) state_d = ST_RUN;
            ST_RUN:  if (ext_s || !all_rdy) state_d = ST_WAKE;
            default: state_d = ST_OFF;
        endcase
        if (!io_s) state_d = ST_OFF;
    end

    // Purpose: register the mode and the one-cycle mode-change pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            evt_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            evt_q   <= (state_d != state_q);
        end
    end

    // Purpose: hold the start-up time; a cold reset restores the floor value.
    always_ff @(posedge clk) begin
        if (!rst_n || ext_s) begin
            start_q <= FLOOR;
        end else if (cfg_we_i && (cfg_addr_i == INDEX)) begin
            start_q <= (cfg_wdata_i < FLOOR) ? FLOOR : cfg_wdata_i;
        end
    end

    // Purpose: latch a start-up window that closed before all PLLs were ready.
    always_ff @(posedge clk) begin
        if (!rst_n || ext_s) begin
            timeout_q <= 1'b0;
        end else if ((state_q == ST_WAKE) && expired && !all_rdy) begin
            timeout_q <= 1'b1;
        end
    end

    assign cfg_rdata_o = start_q;
    assign rst_drv_o   = (state_q != ST_RUN);
    assign pwr_off_o   = (state_q == ST_OFF);
    assign timeout_o   = timeout_q;
    assign mode_evt_o  = evt_q;
endmodule

// File: rtl/pwr_wake_seq_chk.sv
// Checker for the wake sequencer. It looks at the ports and at the
// synchronized cold reset, and is bound into every instance of the top.
module pwr_wake_seq_chk #(
    parameter int UNIT_W    = 5,
    parameter int MIN_UNITS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              io_rst_n_i,
    input logic [3:0]        pll_rdy_i,
    input logic [3:0]        pll_en_o,
    input logic              rst_drv_o,
    input logic              pwr_off_o,
    input logic              timeout_o,
    input logic              mode_evt_o,
    input logic [UNIT_W-1:0] cfg_rdata_o,
    input logic              ext_s
);
    // R1: power-off keeps every PLL disabled and reset held
    a_r1_off_plls_down: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_off_o |-> (pll_en_o == 4'b0000) && rst_drv_o);

    // R1: three edges of low I/O reset reach power-off
    a_r1_io_low_enters_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(io_rst_n_i, 1) && !$past(io_rst_n_i, 2) && !$past(io_rst_n_i, 3))
        |-> pwr_off_o);

    // R2: low-speed PLL enable needs the intermediate PLL ready
    a_r2_low_needs_mid: assert property (@(posedge clk) disable iff (!rst_n)
        pll_en_o[1] |-> pll_rdy_i[0]);

    // R2: fast PLL enables need both earlier PLLs ready
    a_r2_fast_needs_base: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_en_o[2] || pll_en_o[3]) |-> (pll_rdy_i[0] && pll_rdy_i[1]));

    // R3: losing any ready flag while running reasserts reset
    a_r3_loss_reasserts: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_drv_o && !(&pll_rdy_i)) |=> rst_drv_o);

    // R4: reset releases only with all PLLs ready and I/O reset inactive
    a_r4_release_conditions: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_drv_o) |-> ($past(&pll_rdy_i) && $past(io_rst_n_i)));

    // R5: the start-up register never holds a value below the floor
    a_r5_reg_floor: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata_o >= UNIT_W'(MIN_UNITS));

    // R8: the timeout flag clears only through a cold reset
    a_r8_timeout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(timeout_o) |-> $past(ext_s));

    // R9: every mode change comes with the event pulse
    a_r9_evt_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pwr_off_o) || $fell(pwr_off_o) || $rose(rst_drv_o) || $fell(rst_drv_o))
        |-> mode_evt_o);
endmodule

bind pwr_wake_seq pwr_wake_seq_chk #(.UNIT_W(UNIT_W), .MIN_UNITS(MIN_UNITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_rst_n_i  (io_rst_n_i),
    .pll_rdy_i   (pll_rdy_i),
    .pll_en_o    (pll_en_o),
    .rst_drv_o   (rst_drv_o),
    .pwr_off_o   (pwr_off_o),
    .timeout_o   (timeout_o),
    .mode_evt_o  (mode_evt_o),
    .cfg_rdata_o (cfg_rdata_o),
    .ext_s       (ext_s)
);

// File: tb/pwr_wake_seq_tb.sv
module pwr_wake_seq_tb;
    localparam int TPU = 1048;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_rst_i = 1'b0;
    logic       io_rst_n_i = 1'b0;
    logic [3:0] pll_rdy_i = 4'b0000;
    logic       cfg_we_i = 1'b0;
    logic [7:0] cfg_addr_i = 8'h00;
    logic [4:0] cfg_wdata_i = 5'd0;
    logic [4:0] cfg_rdata_o;
    logic [3:0] pll_en_o;
    logic       rst_drv_o;
    logic       pwr_off_o;
    logic       timeout_o;
    logic       mode_evt_o;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int t0 = 0;
    int evt_cnt = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pwr_wake_seq #(.TICKS_PER_UNIT(TPU)) u_dut (
        .clk(clk), .rst_n(rst_n), .ext_rst_i(ext_rst_i), .io_rst_n_i(io_rst_n_i),
        .pll_rdy_i(pll_rdy_i), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
        .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o), .pll_en_o(pll_en_o),
        .rst_drv_o(rst_drv_o), .pwr_off_o(pwr_off_o), .timeout_o(timeout_o),
        .mode_evt_o(mode_evt_o)
    );

    always @(negedge clk) if (rst_n && mode_evt_o) evt_cnt++;

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            cyc++;
        end
        #1;
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) tick(1);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [4:0] d);
        cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
        tick(1);
        cfg_we_i = 1'b0;
        tick(1);
    endtask

    // Raise I/O reset and check the release window for a start-up of l units.
    task automatic wake_window(input int l, input string req);
        io_rst_n_i = 1'b1;
        t0 = cyc;
        wait_until(t0 + l * TPU - 6);
        chk({req, " reset held before window end"}, int'(rst_drv_o), 1);
        wait_until(t0 + l * TPU + 10);
        chk({req, " reset released after window"}, int'(rst_drv_o), 0);
    endtask

    task automatic go_off(input string req);
        io_rst_n_i = 1'b0;
        tick(5);
        chk({req, " power-off flag"}, int'(pwr_off_o), 1);
        chk({req, " PLLs disabled"}, int'(pll_en_o), 0);
        chk({req, " reset held"}, int'(rst_drv_o), 1);
    endtask

    task automatic t_reset;
        tick(4);
        chk("R10 pwr_off", int'(pwr_off_o), 1);
        chk("R10 rst_drv", int'(rst_drv_o), 1);
        chk("R10 pll_en", int'(pll_en_o), 0);
        chk("R10 timeout", int'(timeout_o), 0);
        chk("R10 mode_evt", int'(mode_evt_o), 0);
        chk("R10 start reg", int'(cfg_rdata_o), 8);
        rst_n = 1'b1;
        tick(3);
    endtask

    task automatic t_chain;
        int e0;
        e0 = evt_cnt;
        io_rst_n_i = 1'b1;
        t0 = cyc;
        tick(5);
        chk("R2 only intermediate enabled", int'(pll_en_o), 4'b0001);
        pll_rdy_i = 4'b0001; #1;
        chk("R2 low-speed follows intermediate", int'(pll_en_o), 4'b0011);
        pll_rdy_i = 4'b0011; #1;
        chk("R2 fast PLLs follow base", int'(pll_en_o), 4'b1111);
        pll_rdy_i = 4'b0010; #1;
        chk("R2 low-speed ready alone", int'(pll_en_o), 4'b0001);
        pll_rdy_i = 4'b1111;
        wait_until(t0 + 8 * TPU - 6);
        chk("R4 reset held before 256 ms", int'(rst_drv_o), 1);
        wait_until(t0 + 8 * TPU + 10);
        chk("R4 reset released after 256 ms", int'(rst_drv_o), 0);
        chk("R9 two mode pulses on wake", evt_cnt - e0, 2);
    endtask

    task automatic t_loss;
        int e0;
        e0 = evt_cnt;
        pll_rdy_i = 4'b1101; #1;
        chk("R3 fast enables drop with low-speed", int'(pll_en_o), 4'b0011);
        tick(1);
        chk("R3 reset reasserted", int'(rst_drv_o), 1);
        pll_rdy_i = 4'b1111;
        t0 = cyc;
        wait_until(t0 + 8 * TPU - 6);
        chk("R3 full window after loss", int'(rst_drv_o), 1);
        wait_until(t0 + 8 * TPU + 10);
        chk("R3 released again", int'(rst_drv_o), 0);
        chk("R9 pulses on loss and recovery", evt_cnt - e0, 2);
    endtask

    task automatic t_cfg;
        cfg_write(8'h8E, 5'd12);
        chk("R5 other address ignored", int'(cfg_rdata_o), 8);
        cfg_write(8'h8F, 5'd3);
        chk("R5 clamp to floor", int'(cfg_rdata_o), 8);
        cfg_write(8'h8F, 5'd31);
        chk("R5 maximum stored", int'(cfg_rdata_o), 31);
        cfg_write(8'h8F, 5'd9);
        chk("R5 value stored", int'(cfg_rdata_o), 9);
        go_off("R1 off from run");
        chk("R6 value kept over power-off", int'(cfg_rdata_o), 9);
        wake_window(9, "R4 programmed 288 ms");
    endtask

    task automatic t_abort;
        go_off("R1 off before abort");
        io_rst_n_i = 1'b1;
        tick(4 * TPU);
        go_off("R7 abort mid wake");
        wake_window(9, "R7 timer cleared by abort");
    endtask

    task automatic t_timeout;
        go_off("R1 off before timeout");
        pll_rdy_i = 4'b0001;
        io_rst_n_i = 1'b1;
        t0 = cyc;
        wait_until(t0 + 9 * TPU + 20);
        chk("R8 timeout raised", int'(timeout_o), 1);
        chk("R8 reset held while not ready", int'(rst_drv_o), 1);
        chk("R2 partial chain", int'(pll_en_o), 4'b0011);
        pll_rdy_i = 4'b1111;
        tick(3);
        chk("R8 release once ready", int'(rst_drv_o), 0);
        chk("R8 timeout sticky", int'(timeout_o), 1);
    endtask

    task automatic t_cold;
        ext_rst_i = 1'b1;
        tick(5);
        chk("R6 cold reset restores 256 ms", int'(cfg_rdata_o), 8);
        chk("R6 cold reset clears timeout", int'(timeout_o), 0);
        chk("R4 external reset holds reset", int'(rst_drv_o), 1);
        tick(20);
        chk("R4 held while external reset active", int'(rst_drv_o), 1);
        ext_rst_i = 1'b0;
        t0 = cyc;
        wait_until(t0 + 8 * TPU - 6);
        chk("R6 default window held", int'(rst_drv_o), 1);
        wait_until(t0 + 8 * TPU + 10);
        chk("R6 default window released", int'(rst_drv_o), 0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        t_reset();
        t_chain();
        t_loss();
        t_cfg();
        t_abort();
        t_timeout();
        t_cold();
        finish_run();
    end
endmodule